// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each access of a short burst on a synchronous memory port. A burst starts when the block loads a starting address. Each later step moves the two low address bits to the next of four positions, and the bits above them pass through unchanged. A mode input picks the order of the steps. When the mode input is low, the low bits count up by one and wrap modulo four. When it is high, the low bits are the starting low bits XOR a beat counter that runs 0, 1, 2, 3.

The block also records the write-enable sample at the moment of the load. It reports that read or write type on every beat until the next load. Advancing reads neither the write-enable sample nor anything else on the port. When the clock enable is high, an edge does nothing, so all state holds. Both outputs change on the clock edge after the operation that causes them. The mode input is applied to the stored state as it is, and is meant to be tied to a fixed level.

Top module: `burst_addr_seq`

## Requirements
- R1: During reset, `burst_addr` is all zeros and `burst_is_write` is 0.
- R2: A rising edge with `clk_en_n` low and `load_n` low stores `start_addr` and restarts the beat count. From the next edge, `burst_addr` equals `start_addr` exactly.
- R3: With `interleave` low, each step (`clk_en_n` low, `load_n` high) sets `burst_addr[1:0]` to the previous value plus 1 modulo 4. For a start of 1 this gives 1,2,3,0. `burst_addr[ADDR_W-1:2]` stays equal to the loaded upper bits.
- R4: With `interleave` high, beat k of a burst (k = 0..3) has `burst_addr[1:0]` equal to `start_addr[1:0] XOR k`. For a start of 1 this gives 1,0,3,2. The upper bits stay as loaded.
- R5: `burst_is_write` becomes 1 when `wr_n` is low at the load, and 0 when it is high. It holds through every step whatever `wr_n` does.
- R6: On an edge where `clk_en_n` is high, neither a step nor a load takes place, and both outputs keep their values.
- R7: A burst advanced beyond four beats returns to the starting address on beat 4 and repeats the same order.
- R8: A load in the middle of a burst discards the old burst and starts the new one at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| load_n | input | 1 | Low loads a new start address; high advances the burst |
| interleave | input | 1 | Burst order: 0 linear, 1 XOR-interleaved |
| start_addr | input | ADDR_W | Starting address of a burst |
| wr_n | input | 1 | Write-enable sample, low means write, taken at the load |
| burst_addr | output | ADDR_W | Address of the current beat |
| burst_is_write | output | 1 | 1 while the current burst is a write |

## Verification
The bench builds the block with ADDR_W set to 12. This keeps a distinct, non-zero upper-bit pattern per burst small enough to check in full on every beat. Both values of the mode input are run with each of the four starting low-bit offsets, and each burst is stepped seven times, so the return to the start after beat four is exercised in both orders. Bursts with `clk_en_n` held high and loads in mid-burst are also run, while `wr_n` toggles throughout.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              load_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_n,
  output logic [ADDR_W-1:0] burst_addr,
  output logic              burst_is_write
);
  localparam int LOW_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  beat_q;
  logic              wr_q;
  logic              do_load;
  logic              do_step;
  logic [LOW_W-1:0]  low;

  assign do_load = !clk_en_n && !load_n;
  assign do_step = !clk_en_n && load_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      wr_q   <= 1'b0;
    end else if (do_load) begin
      base_q <= start_addr;
      beat_q <= '0;
      wr_q   <= !wr_n;
    end else if (do_step) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low = interleave ? (base_q[LOW_W-1:0] ^ beat_q)
                          : (base_q[LOW_W-1:0] + beat_q);

  assign burst_addr     = {base_q[ADDR_W-1:LOW_W], low};
  assign burst_is_write = wr_q;
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              load_n,
  input logic              interleave,
  input logic [ADDR_W-1:0] start_addr,
  input logic              wr_n,
  input logic [ADDR_W-1:0] burst_addr,
  input logic              burst_is_write
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  always_comb
    if (!rst_n) AST_RESET_ZERO: assert (burst_addr == '0 && !burst_is_write); // R1

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clk_en_n && !load_n) |=> burst_addr == $past(start_addr)); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clk_en_n && load_n && !interleave) |=>
      (interleave || burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1)); // R3

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clk_en_n && load_n) |=>
      burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])); // R3

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clk_en_n && !load_n) |=> burst_is_write == !$past(wr_n)); // R5

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clk_en_n && load_n) |=> $stable(burst_is_write)); // R5

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clk_en_n) |=>
      ($stable(burst_is_write) && (!$stable(interleave) || $stable(burst_addr)))); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
  .interleave(interleave), .start_addr(start_addr), .wr_n(wr_n),
  .burst_addr(burst_addr), .burst_is_write(burst_is_write)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  // Rows: starting offset 0..3; beat k sits in bits [2k+1:2k]
  localparam logic [7:0] LIN_TAB [4] = '{8'b11_10_01_00, 8'b00_11_10_01,
                                         8'b01_00_11_10, 8'b10_01_00_11};
  localparam logic [7:0] ILV_TAB [4] = '{8'b11_10_01_00, 8'b10_11_00_01,
                                         8'b01_00_11_10, 8'b00_01_10_11};

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en_n = 1'b1, load_n = 1'b1, interleave = 1'b0, wr_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] burst_addr;
  logic          burst_is_write;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
    .interleave(interleave), .start_addr(start_addr), .wr_n(wr_n),
    .burst_addr(burst_addr), .burst_is_write(burst_is_write));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [AW-1:0] a; logic w; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [AW-1:0] m_base = '0;
  int            m_k = 0;
  logic          m_wr = 1'b0;

  function automatic logic [AW-1:0] model_addr(input logic md);
    logic [7:0] row;
    int b;
    row = md ? ILV_TAB[m_base[1:0]] : LIN_TAB[m_base[1:0]];
    b = m_k % 4;
    return {m_base[AW-1:2], row[2*b +: 2]};
  endfunction

  task automatic drive(input logic cen, input logic ld, input logic md,
                       input logic [AW-1:0] sa, input logic wn, input bit mid);
    exp_t e;
    @(negedge clk);
    clk_en_n = cen; load_n = ld; interleave = md; start_addr = sa; wr_n = wn;
    if (cen) e.tag = "R6";
    else if (!ld) begin
      e.tag = mid ? "R8" : "R2";
      m_base = sa; m_k = 0; m_wr = !wn;
    end else begin
      m_k++;
      e.tag = (m_k >= 4) ? "R7" : (md ? "R4" : "R3");
    end
    e.a = model_addr(md);
    e.w = m_wr;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (burst_addr !== e.a) begin
          fails++;
          $display("FAIL %s addr actual=%h expected=%h", e.tag, burst_addr, e.a);
        end
        checks++;
        if (burst_is_write !== e.w) begin
          fails++;
          $display("FAIL R5 (%s) write flag actual=%b expected=%b", e.tag, burst_is_write, e.w);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    checks++; // R1
    if (burst_addr !== '0 || burst_is_write !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", burst_addr, burst_is_write);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] sa;
        sa = {10'(12'h5A3 + 37*s + 101*md), 2'(s)};
        drive(1'b0, 1'b0, md[0], sa, s[0], 1'b0);
        for (int k = 0; k < 7; k++)
          drive(1'b0, 1'b1, md[0], ~sa, k[0], 1'b0);
      end
    end

    // R6: frozen edges with load and step requests present
    drive(1'b0, 1'b0, 1'b0, 12'hB72, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 12'h000, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 12'h3C5, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 12'h3C5, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 12'h3C5, 1'b1, 1'b0);

    // R8: reload mid-burst in both orders
    drive(1'b0, 1'b0, 1'b1, 12'h9E6, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 12'h000, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 12'h417, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1, 12'h000, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 12'h000, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 12'h0A1, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 1'b0);

    @(negedge clk);
    clk_en_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule